// File: doc/BRIEF.md
# I2S to balanced right-justified reformatter

This block sits between an I2S source and a pair of multibit audio DACs wired as a balanced output. It takes in the I2S bit clock, word select and serial data. The stream carries 16-bit two's complement samples in 32-bit channel slots. The block captures each sample and sends it out again as an 18-bit right-justified word, MSB first. The word's last bit lands just before the word-clock edge that latches it into the DAC.

There are two output data lines. The first carries the sample sign-extended to 18 bits. The second carries the exact arithmetic negative of that value, not its bitwise complement. This keeps the two halves of the balanced pair symmetric to the last LSB. The block also regenerates the DAC bit clock and a word clock whose polarity latches the left word on a falling edge.

The block runs from one fast system clock. It oversamples the I2S lines through synchronisers and acts on the edges of the bit clock it detects.

Top module: `i2s_balanced_rj`

## Requirements
- R1: While reset is asserted, and for the first two word-clock edges after it, both data lines and the word clock are low and every latched word is zero.
- R2: An input slot starts on the first rising bit-clock edge after word select changes. The 16 sample bits are taken MSB first on the 2nd to 17th rising edges of the slot. The other 16 bit positions of the slot are ignored.
- R3: The positive line sends the sample sign-extended to 18 bits, MSB first.
- R4: The negated line sends the 18-bit two's complement negative of the sign-extended sample. The two latched words sum to zero modulo 2^18, and an input of 0x8000 yields 0x08000 on the negated line.
- R5: Each 32-bit output slot begins with 14 zero bits on both lines, followed by the 18 word bits, so the LSB sits in the slot's last bit position.
- R6: The word clock toggles on the falling bit-clock edge that follows the rising edge at which the DAC takes the LSB. Consecutive word-clock edges are 32 bit clocks apart.
- R7: A word taken from a slot with word select low (left) is latched by a falling word-clock edge. A word from a slot with word select high (right) is latched by a rising edge.
- R8: A sample captured in input slot N is sent during slot N+1 and latched at the start of slot N+2.
- R9: The data lines and the word clock change only at a falling edge of the output bit clock. Both data lines come from the same register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_bclk | input | 1 | I2S bit clock |
| i2s_ws | input | 1 | I2S word select, low for left |
| i2s_sd | input | 1 | I2S serial data |
| dac_bclk | output | 1 | Regenerated bit clock for the DACs |
| dac_wclk | output | 1 | Regenerated word clock; falling edge latches left, rising latches right |
| dac_data | output | 1 | Sign-extended sample, 18 bits, MSB first |
| dac_data_inv | output | 1 | Arithmetic negation of the sample, 18 bits, MSB first |

## Verification
A slip of the slot position counter moves the word inside the output slot. The latched words then come out scaled or shifted, and the pad bits turn nonzero, at the second word-clock edge after the fault. A wrong held sample or a wrong negation shows at the next latch: the positive and negated words no longer sum to zero, so every word is tested against both the table value and the pair identity. A wrong channel flag flips the word-clock phase. This is seen one slot later as a word latched on the wrong edge polarity.

// File: rtl/i2s_brj_pkg.sv
package i2s_brj_pkg;
    // Channel carried by a slot; encoding equals the I2S word-select level.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/brj_capture.sv
module brj_capture
    import i2s_brj_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32,
    parameter int POS_W    = $clog2(SLOT_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_rise,
    input  logic                ws_in,
    input  logic                sd_in,
    output logic [POS_W-1:0]    slot_pos,
    output logic [SAMPLE_W-1:0] held_sample,
    output chan_e               held_ch
);
    localparam logic [POS_W-1:0] FIRST_BIT = POS_W'(1);
    localparam logic [POS_W-1:0] LAST_BIT  = POS_W'(SAMPLE_W);

    typedef struct packed {
        logic [POS_W-1:0]    pos;
        logic                ws_prev;
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] held;
        chan_e               ch;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (bclk_rise) begin
            cap_d.ws_prev = ws_in;
            // R2: slot realigns on a word-select change
            if (ws_in != cap_q.ws_prev) begin
                cap_d.pos = '0;
            end else begin
                cap_d.pos = cap_q.pos + 1'b1;
            end
            if (cap_d.pos >= FIRST_BIT && cap_d.pos <= LAST_BIT) begin
                cap_d.shreg = {cap_q.shreg[SAMPLE_W-2:0], sd_in};
            end
            if (cap_d.pos == LAST_BIT) begin
                cap_d.held = {cap_q.shreg[SAMPLE_W-2:0], sd_in};
                cap_d.ch   = chan_e'(ws_in);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign slot_pos    = cap_q.pos;
    assign held_sample = cap_q.held;
    assign held_ch     = cap_q.ch;
endmodule

// File: rtl/brj_negate.sv
module brj_negate #(
    parameter int SAMPLE_W = 16,
    parameter int DAC_W    = 18
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [DAC_W-1:0]    pos_word,
    output logic [DAC_W-1:0]    neg_word
);
    localparam int EXT_W = DAC_W - SAMPLE_W;

    generate
        if (EXT_W > 0) begin : g_extend
            // R3: widen so that negating the most negative input cannot overflow
            assign pos_word = {{EXT_W{sample[SAMPLE_W-1]}}, sample};
        end else begin : g_same
            assign pos_word = sample[DAC_W-1:0];
        end
    endgenerate

    // R4: true two's complement negation
    assign neg_word = ~pos_word + 1'b1;
endmodule

// File: rtl/brj_serializer.sv
module brj_serializer
    import i2s_brj_pkg::*;
#(
    parameter int DAC_W  = 18,
    parameter int SLOT_W = 32,
    parameter int POS_W  = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_level,
    input  logic             bclk_fall,
    input  logic [POS_W-1:0] slot_pos,
    input  logic [DAC_W-1:0] pos_word,
    input  logic [DAC_W-1:0] neg_word,
    input  chan_e            word_ch,
    output logic             dac_bclk,
    output logic             dac_wclk,
    output logic             dac_data,
    output logic             dac_data_inv,
    output logic [DAC_W-1:0] sh_pos,
    output logic [DAC_W-1:0] sh_neg
);
    localparam logic [POS_W-1:0] LOAD_POS = POS_W'(SLOT_W - DAC_W);
    localparam logic [POS_W-1:0] EDGE_POS = '0;

    typedef struct packed {
        logic             bclk;
        logic             wclk;
        logic             dp;
        logic             dn;
        logic [DAC_W-1:0] shp;
        logic [DAC_W-1:0] shn;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.bclk = bclk_level;
        if (bclk_fall) begin
            // R5: word placed so its LSB fills the last slot position
            if (slot_pos == LOAD_POS) begin
                tx_d.dp  = pos_word[DAC_W-1];
                tx_d.dn  = neg_word[DAC_W-1];
                tx_d.shp = {pos_word[DAC_W-2:0], 1'b0};
                tx_d.shn = {neg_word[DAC_W-2:0], 1'b0};
            end else begin
                tx_d.dp  = tx_q.shp[DAC_W-1];
                tx_d.dn  = tx_q.shn[DAC_W-1];
                tx_d.shp = {tx_q.shp[DAC_W-2:0], 1'b0};
                tx_d.shn = {tx_q.shn[DAC_W-2:0], 1'b0};
            end
            // R6, R7: word clock moves one bit after the LSB was taken
            if (slot_pos == EDGE_POS) begin
                tx_d.wclk = (word_ch == CH_LEFT);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign dac_bclk     = tx_q.bclk;
    assign dac_wclk     = tx_q.wclk;
    assign dac_data     = tx_q.dp;
    assign dac_data_inv = tx_q.dn;
    assign sh_pos       = tx_q.shp;
    assign sh_neg       = tx_q.shn;
endmodule

// File: rtl/i2s_balanced_rj.sv
module i2s_balanced_rj
    import i2s_brj_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int DAC_W       = 18,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i2s_bclk,
    input  logic i2s_ws,
    input  logic i2s_sd,
    output logic dac_bclk,
    output logic dac_wclk,
    output logic dac_data,
    output logic dac_data_inv
);
    localparam int POS_W = $clog2(SLOT_W);
    localparam int TOP   = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] bclk;
        logic [SYNC_STAGES-1:0] ws;
        logic [SYNC_STAGES-1:0] sd;
        logic                   bclk_prev;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.bclk      = {sync_q.bclk[TOP-1:0], i2s_bclk};
        sync_d.ws        = {sync_q.ws[TOP-1:0], i2s_ws};
        sync_d.sd        = {sync_q.sd[TOP-1:0], i2s_sd};
        sync_d.bclk_prev = sync_q.bclk[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    logic bclk_rise, bclk_fall;
    assign bclk_rise = sync_q.bclk[TOP] & ~sync_q.bclk_prev;
    assign bclk_fall = ~sync_q.bclk[TOP] & sync_q.bclk_prev;

    logic [POS_W-1:0]    slot_pos;
    logic [SAMPLE_W-1:0] held_sample;
    chan_e               held_ch;
    logic [DAC_W-1:0]    pos_word, neg_word;
    logic [DAC_W-1:0]    tx_sh_pos, tx_sh_neg;

    brj_capture #(
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W),
        .POS_W    (POS_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .ws_in       (sync_q.ws[TOP]),
        .sd_in       (sync_q.sd[TOP]),
        .slot_pos    (slot_pos),
        .held_sample (held_sample),
        .held_ch     (held_ch)
    );

    brj_negate #(
        .SAMPLE_W (SAMPLE_W),
        .DAC_W    (DAC_W)
    ) u_neg (
        .sample   (held_sample),
        .pos_word (pos_word),
        .neg_word (neg_word)
    );

    brj_serializer #(
        .DAC_W  (DAC_W),
        .SLOT_W (SLOT_W),
        .POS_W  (POS_W)
    ) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_level   (sync_q.bclk[TOP]),
        .bclk_fall    (bclk_fall),
        .slot_pos     (slot_pos),
        .pos_word     (pos_word),
        .neg_word     (neg_word),
        .word_ch      (held_ch),
        .dac_bclk     (dac_bclk),
        .dac_wclk     (dac_wclk),
        .dac_data     (dac_data),
        .dac_data_inv (dac_data_inv),
        .sh_pos       (tx_sh_pos),
        .sh_neg       (tx_sh_neg)
    );
endmodule

// File: rtl/brj_checker.sv
module brj_checker #(
    parameter int DAC_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dac_bclk,
    input logic             dac_wclk,
    input logic             dac_data,
    input logic             dac_data_inv,
    input logic [DAC_W-1:0] sh_pos,
    input logic [DAC_W-1:0] sh_neg
);
    // R4: remaining bits of the pair still cancel while shifting
    a_r4_pair_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        DAC_W'(sh_pos + sh_neg) == '0);

    // R9: data lines move together, only when the output bit clock falls
    a_r9_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(dac_bclk) |-> ($stable(dac_data) && $stable(dac_data_inv)));

    // R9: word clock also moves only at a falling bit-clock edge
    a_r9_wclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(dac_bclk) |-> $stable(dac_wclk));

    // R6: a word-clock edge finds the word fully shifted out
    a_r6_latch_after_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_wclk) |-> (sh_pos == '0 && sh_neg == '0));
endmodule

bind i2s_balanced_rj brj_checker #(.DAC_W(DAC_W)) u_brj_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dac_bclk     (dac_bclk),
    .dac_wclk     (dac_wclk),
    .dac_data     (dac_data),
    .dac_data_inv (dac_data_inv),
    .sh_pos       (tx_sh_pos),
    .sh_neg       (tx_sh_neg)
);

// File: tb/i2s_balanced_rj_bench.sv
module i2s_balanced_rj_bench;
    localparam int HALF  = 8;
    localparam int NVEC  = 10;
    localparam int NRAND = 8;
    localparam int NDATA = 1 + NVEC + NRAND;

    // [33:18] input sample, [17:0] expected negated word
    localparam logic [33:0] VEC [NVEC] = '{
        {16'h0000, 18'h00000},
        {16'hFFFF, 18'h00001},
        {16'h7FFF, 18'h38001},
        {16'h8000, 18'h08000},
        {16'h0001, 18'h3FFFF},
        {16'h1234, 18'h3EDCC},
        {16'hFEDC, 18'h00124},
        {16'h4000, 18'h3C000},
        {16'hC000, 18'h04000},
        {16'h0100, 18'h3FF00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk = 1'b0, ws = 1'b0, sd = 1'b0;
    logic dac_bclk, dac_wclk, dac_data, dac_data_inv;

    always #4 clk = ~clk;

    i2s_balanced_rj u_i2s_balanced_rj (
        .clk          (clk),
        .rst_n        (rst_n),
        .i2s_bclk     (bclk),
        .i2s_ws       (ws),
        .i2s_sd       (sd),
        .dac_bclk     (dac_bclk),
        .dac_wclk     (dac_wclk),
        .dac_data     (dac_data),
        .dac_data_inv (dac_data_inv)
    );

    int checks = 0, errors = 0;
    int ev = 0, matched = 0, bits_since = 0;
    bit done = 1'b0;
    logic [15:0] exp_s  [NDATA];
    logic [17:0] exp_n  [NDATA];
    logic        exp_ws [NDATA];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic send_slot(input logic wsv, input logic [15:0] w);
        for (int b = 0; b < 32; b++) begin
            ws = wsv;
            // R2: positions outside the 16 sample bits carry junk
            sd = (b >= 1 && b <= 16) ? w[16-b] : 1'($urandom % 2);
            repeat (HALF) @(negedge clk);
            bclk = 1'b1;
            repeat (HALF) @(negedge clk);
            bclk = 1'b0;
        end
    endtask

    task automatic on_latch(input logic [31:0] rp, input logic [31:0] rn, input logic wnew);
        if (ev >= 1)
            check(bits_since == 32, "R6", "bits between word-clock edges", 32'(bits_since), 32'd32);
        if (ev < 2) begin
            check(rp == '0 && rn == '0, "R1", "word latched after reset", rp | rn, 32'd0);
        end else if (ev - 2 < NDATA) begin
            int idx;
            logic [17:0] ep;
            idx = ev - 2;
            ep  = {{2{exp_s[idx][15]}}, exp_s[idx]};
            check(rp[17:0] == ep, "R2 R3", "positive word", 32'(rp[17:0]), 32'(ep));
            check(rn[17:0] == exp_n[idx], "R4", "negated word", 32'(rn[17:0]), 32'(exp_n[idx]));
            check(18'(rp[17:0] + rn[17:0]) == 18'd0, "R4", "pair sum",
                  32'(18'(rp[17:0] + rn[17:0])), 32'd0);
            check(rp[31:18] == '0 && rn[31:18] == '0, "R5", "pad bits",
                  32'({rp[31:18], rn[31:18]}), 32'd0);
            // R7: falling edge (new level 0) latches left, rising latches right; R8 order
            check(wnew == exp_ws[idx], "R7 R8", "latch polarity", 32'(wnew), 32'(exp_ws[idx]));
            matched++;
        end
        ev++;
        bits_since = 0;
    endtask

    // DAC-side receiver
    initial begin
        logic [31:0] rp = '0, rn = '0;
        logic wprev = 1'b0;
        forever begin
            logic dp, dn, w;
            @(posedge dac_bclk);
            @(negedge clk);
            dp = dac_data; dn = dac_data_inv; w = dac_wclk;
            if (w !== wprev) on_latch(rp, rn, w);
            rp = {rp[30:0], dp};
            rn = {rn[30:0], dn};
            bits_since++;
            wprev = w;
            repeat (HALF - 2) @(negedge clk);
            check(dac_bclk == 1'b1 && dac_data == dp && dac_data_inv == dn && dac_wclk == w,
                  "R9", "outputs steady while bit clock high",
                  32'({dac_bclk, dac_data, dac_data_inv, dac_wclk}), 32'({1'b1, dp, dn, w}));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog expired actual %0d words expected %0d", matched, NDATA);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_s[0] = 16'h0000; exp_n[0] = 18'h0; exp_ws[0] = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            exp_s[1+i]  = VEC[i][33:18];
            exp_n[1+i]  = VEC[i][17:0];
            exp_ws[1+i] = 1'(i % 2);
        end
        for (int i = 0; i < NRAND; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            exp_s[1+NVEC+i]  = r;
            exp_n[1+NVEC+i]  = 18'(-$signed({{2{r[15]}}, r}));
            exp_ws[1+NVEC+i] = 1'((NVEC + i) % 2);
        end

        repeat (10) @(negedge clk);
        check({dac_bclk, dac_wclk, dac_data, dac_data_inv} == 4'b0, "R1", "outputs in reset",
              32'({dac_bclk, dac_wclk, dac_data, dac_data_inv}), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int k = 0; k < NDATA; k++) send_slot(exp_ws[k], exp_s[k]);
        send_slot(1'b0, 16'h0000);
        send_slot(1'b1, 16'h0000);
        repeat (40) @(negedge clk);
        check(matched == NDATA, "R8", "words latched", 32'(matched), 32'(NDATA));

        // R1: reset taken mid-stream clears the outputs
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({dac_bclk, dac_wclk, dac_data, dac_data_inv} == 4'b0, "R1", "outputs after late reset",
              32'({dac_bclk, dac_wclk, dac_data, dac_data_inv}), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule